// File: doc/BRIEF.md
# Auto-reload square-wave generator

This block turns the system oscillator into a programmable square wave for a port pin. A counter of `CNT_W` bits (16 by default) advances once every two oscillator cycles. When it wraps past its all-ones value, it loads a software-written reload value and the output level flips. Each half-period is therefore `2*(2^CNT_W - reload)` clocks, and the duty cycle is exactly 50%. With the default width and a 16 MHz oscillator, the output spans roughly 61 Hz to 4 MHz.

Software programs the block through a byte-wide write port with three registers:

- **Control register:** holds the run, pin-select and count-source bits.
- **Reload low register:** holds the low byte of the reload value.
- **Reload high register:** holds the upper bits of the reload value.

The pin is given to the wave only when the pin-select bit is set and the count-source bit is clear. Otherwise the pin carries the ordinary port data. A one-cycle overflow flag marks every wrap. Counting from an external input is not part of this block: selecting that source freezes the counter.

Top module: `sqw_reload_gen`

## Requirements
- R1: After a synchronous reset, `clk_out`, `ovf_flag` and `alt_sel` are 0, all register bits and the counter are 0, and `pin_out` equals `port_data`.
- R2: While running, consecutive changes of `clk_out` are exactly `2*(2^CNT_W - reload)` clock cycles apart.
- R3: When the block is started from reset with reload 0, the first change of `clk_out` comes `2*2^CNT_W` cycles after the edge that writes the run bit.
- R4: A reload value written mid-period does not shorten or lengthen the period in progress. It sets the length of the next period only.
- R5: While the run bit (control bit 0) is 0, the counter holds, `clk_out` keeps its level and `ovf_flag` stays 0. On restart, counting resumes with the programmed period.
- R6: `alt_sel` is 1 exactly when the pin-select bit (control bit 1) is 1 and the count-source bit (control bit 2) is 0. When `alt_sel` is 1, `pin_out` follows `clk_out`; otherwise it follows `port_data`.
- R7: While the count-source bit (control bit 2) is 1, the counter does not advance, `clk_out` does not change and `ovf_flag` stays 0.
- R8: `ovf_flag` is high for one cycle on each wrap, in the same cycle that `clk_out` takes its new level.
- R9: A reload of all ones gives a change of `clk_out` every 2 cycles. A reload of 0 gives a change every `2*2^CNT_W` cycles.
- R10: The write address selects the register: 0 is control, 1 is reload bits 7:0, 2 is reload bits `CNT_W-1`:8 (taken from `wr_data` low bits). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| port_data | input | 1 | Ordinary port output level |
| clk_out | output | 1 | Square-wave level |
| pin_out | output | 1 | Level driven on the pin |
| alt_sel | output | 1 | High when the pin carries the wave |
| ovf_flag | output | 1 | One-cycle pulse per counter wrap |

## Verification
The hardest case to reach is a reload write that lands inside a running period, because the write must arrive after one wrap and before the next. The stimulus waits for a level change and then issues both reload writes at once. It sets the old reload so that the period is long enough to take those writes. It then measures the period that straddles the writes and the period after it separately. Random reloads near the top of the range keep the periods short, which leaves cycle budget for the full-length periods given by reload 0.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    typedef enum logic [1:0] {
        ADR_CTL  = 2'd0,
        ADR_RLO  = 2'd1,
        ADR_RHI  = 2'd2,
        ADR_NONE = 2'd3
    } sqw_addr_e;

    typedef struct packed {
        logic src_ext;
        logic out_en;
        logic run;
    } sqw_ctl_t;

    function automatic sqw_ctl_t byte_to_ctl(input logic [7:0] d);
        sqw_ctl_t c;
        c.run     = d[0];
        c.out_en  = d[1];
        c.src_ext = d[2];
        return c;
    endfunction

    function automatic logic pin_owned(input sqw_ctl_t c);
        return c.out_en & ~c.src_ext;
    endfunction

endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
    import sqw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output sqw_ctl_t         ctl,
    output logic [CNT_W-1:0] reload
);
    localparam int HI_W = CNT_W - 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            reload <= '0;
        end else if (wr_en) begin
            case (sqw_addr_e'(wr_addr))
                ADR_CTL: ctl                <= byte_to_ctl(wr_data);
                ADR_RLO: reload[7:0]        <= wr_data;
                ADR_RHI: reload[CNT_W-1:8]  <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // R10: registers change only on a write strobe
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (reload == $past(reload)) && (ctl == $past(ctl)));

endmodule

// File: rtl/sqw_timebase.sv
module sqw_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             roll,
    output logic             ovf_q
);
    logic             ph;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    assign tick = run & ph;
    assign roll = tick & (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= 1'b0;
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= roll;
            if (run) ph <= ~ph;
            if (tick) cnt <= roll ? reload : cnt + 1'b1;
        end
    end

    // R5: a stopped timer holds its count
    p_halt_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == $past(cnt));

    // R4: a wrap loads the reload value present before the wrap edge
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> cnt == $past(reload));

endmodule

// File: rtl/sqw_wave.sv
module sqw_wave
    import sqw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     roll,
    input  sqw_ctl_t ctl,
    input  logic     port_data,
    output logic     wave,
    output logic     alt_sel,
    output logic     pin_out
);
    always_ff @(posedge clk) begin
        if (rst)       wave <= 1'b0;
        else if (roll) wave <= ~wave;
    end

    assign alt_sel = pin_owned(ctl);
    assign pin_out = alt_sel ? wave : port_data;

    // R8: every wrap flips the level
    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        roll |=> wave != $past(wave));

    // R2: without a wrap the level holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !roll |=> wave == $past(wave));

endmodule

// File: rtl/sqw_reload_gen.sv
module sqw_reload_gen
    import sqw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       port_data,
    output logic       clk_out,
    output logic       pin_out,
    output logic       alt_sel,
    output logic       ovf_flag
);
    sqw_ctl_t         ctl;
    logic [CNT_W-1:0] reload;
    logic             roll;
    logic             run_eff;

    assign run_eff = ctl.run & ~ctl.src_ext;

    sqw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctl(ctl), .reload(reload)
    );

    sqw_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .run(run_eff), .reload(reload),
        .roll(roll), .ovf_q(ovf_flag)
    );

    sqw_wave u_wave (
        .clk(clk), .rst(rst), .roll(roll), .ctl(ctl), .port_data(port_data),
        .wave(clk_out), .alt_sel(alt_sel), .pin_out(pin_out)
    );

    // R7: external source selected means no wrap in the next cycle
    p_ext_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.src_ext |=> !ovf_flag);

    // R6: the pin is never handed to the wave while the external source is chosen
    p_pin_owner_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.src_ext |-> !alt_sel);

endmodule

// File: tb/tb_sqw_reload_gen.sv
`timescale 1ns/1ns
module tb_sqw_reload_gen;
    localparam int W = 10;
    localparam int M = 1 << W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       port_data = 1'b0;
    logic       clk_out, pin_out, alt_sel, ovf_flag;

    int total = 0;
    int bad = 0;
    int ntog = 0;
    int novf = 0;
    int iv = 0;
    longint t_last = 0;
    logic last_lvl = 1'b0;
    int wd = 0;

    sqw_reload_gen #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_data(port_data), .clk_out(clk_out),
        .pin_out(pin_out), .alt_sel(alt_sel), .ovf_flag(ovf_flag)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (clk_out !== last_lvl) begin
                iv = int'(($time - t_last) / 20);
                t_last = $time;
                last_lvl = clk_out;
                ntog++;
            end
            if (ovf_flag) novf++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<=%0d", wd, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int half_iv(input int r);
        return 2 * (M - r);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_reload(input int r);
        wr(2'd1, 8'(r & 255));
        wr(2'd2, 8'(r >> 8));
    endtask

    task automatic wait_tog(input int n);
        int target;
        target = ntog + n;
        do @(negedge clk); while (ntog < target);
    endtask

    initial begin
        int r;
        int r_old;
        int r_new;
        int t0;
        int o0;
        int errs;
        logic lvl;
        void'($urandom(32'd2024));
        port_data = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(clk_out == 1'b0, "R1 clk_out", int'(clk_out), 0);
        chk(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
        chk(alt_sel == 1'b0, "R1 alt_sel", int'(alt_sel), 0);
        chk(pin_out == port_data, "R1 pin_out", int'(pin_out), int'(port_data));
        rst = 1'b0;

        // R10/R6: pin select only
        wr(2'd0, 8'h02);
        @(negedge clk);
        chk(alt_sel == 1'b1, "R6 alt_sel on", int'(alt_sel), 1);
        chk(pin_out == clk_out, "R6 pin follows wave", int'(pin_out), int'(clk_out));

        // R3: first wrap from zero
        wr(2'd0, 8'h03);
        t_last = $time;
        wait_tog(1);
        chk(iv == 2 * M, "R3 first period", iv, 2 * M);
        chk(novf == 1, "R8 one flag per wrap", novf, 1);

        // R9: reload zero then all ones
        wait_tog(1);
        chk(iv == half_iv(0), "R9 reload zero", iv, half_iv(0));
        wr_reload(M - 1);
        wait_tog(3);
        chk(iv == 2, "R9 reload max", iv, 2);

        // R2: random reloads
        for (int i = 0; i < 6; i++) begin
            r = M - 20 - int'($urandom % 300);
            wr_reload(r);
            wait_tog(2);
            chk(iv == half_iv(r), "R2 random period", iv, half_iv(r));
            chk(pin_out == clk_out, "R6 pin follows wave", int'(pin_out), int'(clk_out));
        end

        // R4: mid-period reload write
        r_old = M - 40;
        r_new = M - 100;
        wr_reload(r_old);
        wait_tog(3);
        wr_reload(r_new);
        wait_tog(1);
        chk(iv == half_iv(r_old), "R4 period in progress", iv, half_iv(r_old));
        wait_tog(1);
        chk(iv == half_iv(r_new), "R4 next period", iv, half_iv(r_new));

        // R10: unused address ignored
        wr(2'd3, 8'hFF);
        wait_tog(2);
        chk(iv == half_iv(r_new), "R10 addr3 ignored", iv, half_iv(r_new));

        // R8: flags match level changes
        t0 = ntog; o0 = novf;
        wait_tog(4);
        chk((novf - o0) == (ntog - t0), "R8 flag count", novf - o0, ntog - t0);

        // R5: stop holds level
        wr(2'd0, 8'h02);
        @(negedge clk);
        lvl = clk_out; o0 = novf; errs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (clk_out != lvl) errs++;
        end
        chk(errs == 0, "R5 level held", errs, 0);
        chk(novf == o0, "R5 no flag", novf - o0, 0);
        wr(2'd0, 8'h03);
        wait_tog(2);
        chk(iv == half_iv(r_new), "R5 resume period", iv, half_iv(r_new));

        // R7: external source freezes
        wr(2'd0, 8'h07);
        @(negedge clk);
        lvl = clk_out; o0 = novf; errs = 0;
        for (int i = 0; i < 300; i++) begin
            port_data = 1'($urandom);
            @(negedge clk);
            if (clk_out != lvl || pin_out != port_data) errs++;
        end
        chk(errs == 0, "R7 frozen and port pin", errs, 0);
        chk(alt_sel == 1'b0, "R6 alt_sel off ext", int'(alt_sel), 0);
        chk(novf == o0, "R7 no flag", novf - o0, 0);
        wr(2'd0, 8'h03);
        wait_tog(2);
        chk(iv == half_iv(r_new), "R7 resume period", iv, half_iv(r_new));

        // R6: run without pin select
        wr(2'd0, 8'h01);
        errs = 0;
        for (int i = 0; i < 400; i++) begin
            port_data = 1'($urandom);
            @(negedge clk);
            if (pin_out != port_data || alt_sel) errs++;
        end
        t0 = ntog;
        wait_tog(1);
        chk(errs == 0, "R6 port data on pin", errs, 0);
        chk(ntog > t0, "R6 wave keeps running", ntog - t0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule